// File: doc/BRIEF.md
# Parallel-Load Shift Register with Set/Clear/Toggle Entry

This block is a register of `WIDTH` stages (four by default) that updates on the rising clock edge. It has two modes. In load mode, every stage takes its own parallel data bit. In shift mode, the contents move one stage toward the top index. The mode select `load_n` is active low.

In shift mode the bottom stage does not take a plain serial bit. It takes its next value from a set input `ser_j` and an active-low clear input `ser_kb`. With these two inputs the entry stage can be cleared, set, held or toggled. Tying the two inputs together turns the entry into an ordinary D input that follows `ser_j`.

An active-low asynchronous clear empties the whole register. Besides the stage values, the block drives the inverse of the top stage. Shift-left behaviour can be obtained by external wiring: feed each stage output back to the parallel input one index below and hold `load_n` low. This needs no extra logic inside the block.

Top module: `pshift_jk_reg`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros. This takes effect as soon as `rst_n` falls, without waiting for a clock edge.
- R2: Clear has priority over load and shift. After `rst_n` rises, `q` stays zero until the next rising clock edge.
- R3: On a rising edge with `load_n` = 0, each `q[i]` takes `par_d[i]`.
- R4: On a rising edge with `load_n` = 1, each `q[i]` for i ≥ 1 takes the value `q[i-1]` had before that edge. Values do not ripple through more than one stage per edge.
- R5: In shift mode with `ser_j`=0 and `ser_kb`=0, `q[0]` becomes 0.
- R6: In shift mode with `ser_j`=1 and `ser_kb`=1, `q[0]` becomes 1.
- R7: In shift mode with `ser_j`=0 and `ser_kb`=1, `q[0]` keeps its value.
- R8: In shift mode with `ser_j`=1 and `ser_kb`=0, `q[0]` becomes the inverse of its previous value.
- R9: `q_last_n` is always the inverse of `q[WIDTH-1]`.
- R10: Changes on `par_d`, `load_n`, `ser_j` and `ser_kb` between clock edges do not change `q`. Only the values present at the edge matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | 0 selects parallel load, 1 selects shift |
| ser_j | input | 1 | Set input of the entry stage |
| ser_kb | input | 1 | Clear input of the entry stage, active low |
| par_d | input | WIDTH | Parallel load data |
| q | output | WIDTH | Stage values |
| q_last_n | output | 1 | Inverse of the top stage |

## Verification
Parallel loads use the alternating patterns 1010 and 0101 together with all-ones and all-zeros. These patterns separate each stage's own bit from its neighbours and reveal a swapped or stuck bit. Shift runs start from one-hot and mixed contents, which shows whether each stage takes its lower neighbour's old value or a value that has rippled through within the same edge. Each of the four entry combinations is applied from both a 0 and a 1 in the bottom stage, so hold, toggle, set and clear cannot be confused with one another. A clear asserted mid-cycle, an edge seen while clear is held, and a release mid-cycle show that the clear acts immediately and wins over a pending load.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
    typedef enum logic [1:0] {
        ENTRY_CLEAR  = 2'b00,
        ENTRY_HOLD   = 2'b01,
        ENTRY_TOGGLE = 2'b10,
        ENTRY_SET    = 2'b11
    } entry_op_e;
endpackage

// File: rtl/pshift_entry.sv
module pshift_entry
    import pshift_pkg::*;
(
    input  logic      set_in,
    input  logic      clr_in_n,
    input  logic      cur_bit,
    output entry_op_e op,
    output logic      next_bit
);
    always_comb begin
        op = entry_op_e'({set_in, clr_in_n});
        unique case (op)
            ENTRY_CLEAR:  next_bit = 1'b0;
            ENTRY_HOLD:   next_bit = cur_bit;
            ENTRY_TOGGLE: next_bit = ~cur_bit;
            ENTRY_SET:    next_bit = 1'b1;
            default:      next_bit = cur_bit;
        endcase
    end
endmodule

// File: rtl/pshift_next.sv
module pshift_next #(
    parameter int WIDTH = 4
) (
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_d,
    input  logic [WIDTH-1:0] cur,
    input  logic             entry_bit,
    output logic [WIDTH-1:0] nxt
);
    always_comb begin
        nxt[0] = load_n ? entry_bit : par_d[0];
    end

    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
        always_comb begin
            nxt[i] = load_n ? cur[i-1] : par_d[i];
        end
    end
endmodule

// File: rtl/pshift_jk_reg.sv
module pshift_jk_reg
    import pshift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             ser_j,
    input  logic             ser_kb,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q,
    output logic             q_last_n
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stg;
    } reg_s;

    reg_s      st_d, st_q;
    entry_op_e entry_op;
    logic      entry_bit;
    logic [WIDTH-1:0] stg_nxt;

    pshift_entry u_entry (
        .set_in   (ser_j),
        .clr_in_n (ser_kb),
        .cur_bit  (st_q.stg[0]),
        .op       (entry_op),
        .next_bit (entry_bit)
    );

    pshift_next #(.WIDTH(WIDTH)) u_next (
        .load_n    (load_n),
        .par_d     (par_d),
        .cur       (st_q.stg),
        .entry_bit (entry_bit),
        .nxt       (stg_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stg = stg_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q        = st_q.stg;
    assign q_last_n = ~st_q.stg[TOP];

    // R1: register empty whenever clear is held at an edge
    p_clear_r1: assert property (@(posedge clk) !rst_n |-> q == '0);

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_n)) |-> q == $past(par_d));

    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n)) |-> q[TOP:1] == $past(q[TOP-1:0]));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n) && !$past(ser_j) && !$past(ser_kb)) |-> !q[0]);

    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n) && $past(ser_j) && $past(ser_kb)) |-> q[0]);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n) && !$past(ser_j) && $past(ser_kb)) |-> q[0] == $past(q[0]));

    p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n) && $past(ser_j) && !$past(ser_kb)) |-> q[0] != $past(q[0]));
endmodule

// File: tb/tb_pshift_jk_reg.sv
module tb_pshift_jk_reg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         load_n = 1'b0;
    logic         ser_j = 1'b0;
    logic         ser_kb = 1'b0;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] q;
    logic         q_last_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] exp_q = '0;

    pshift_jk_reg #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .ser_j(ser_j),
        .ser_kb(ser_kb), .par_d(par_d), .q(q), .q_last_n(q_last_n)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // R9 checked alongside every output check
    task automatic check_q(input string req);
        check(req, q, exp_q);
        check("R9", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, ~q[W-1]});
    endtask

    // one clock edge: bench model updated from inputs held at the edge
    task automatic tick();
        @(posedge clk);
        if (!rst_n)       exp_q = '0;
        else if (!load_n) exp_q = par_d;
        else begin
            logic e;
            case ({ser_j, ser_kb})
                2'b00: e = 1'b0;
                2'b01: e = exp_q[0];
                2'b10: e = ~exp_q[0];
                default: e = 1'b1;
            endcase
            exp_q = {exp_q[W-2:0], e};
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1 rst_n = 1'b0;
        #2 check_q("R1");
        @(negedge clk);
        rst_n = 1'b1;
        exp_q = '0;
        check_q("R1");
    endtask

    task automatic t_load();
        logic [W-1:0] pats [4] = '{4'b1010, 4'b0101, 4'b1111, 4'b0000};
        foreach (pats[i]) begin
            load_n = 1'b0; par_d = pats[i];
            tick();
            check_q("R3");
        end
    endtask

    task automatic t_shift();
        load_n = 1'b0; par_d = 4'b0001; tick();
        load_n = 1'b1; ser_j = 1'b0; ser_kb = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            check_q("R4");
        end
        load_n = 1'b0; par_d = 4'b0110; tick();
        load_n = 1'b1; ser_j = 1'b1; ser_kb = 1'b1;
        tick(); check_q("R4");
    endtask

    task automatic t_entry();
        for (int start = 0; start < 2; start++) begin
            for (int c = 0; c < 4; c++) begin
                load_n = 1'b0; par_d = {3'b010, start[0]}; tick();
                load_n = 1'b1; {ser_j, ser_kb} = c[1:0];
                tick();
                case (c)
                    0: check_q("R5");
                    1: check_q("R7");
                    2: check_q("R8");
                    default: check_q("R6");
                endcase
            end
        end
        // repeated toggle
        ser_j = 1'b1; ser_kb = 1'b0;
        tick(); check_q("R8");
        tick(); check_q("R8");
    endtask

    task automatic t_mid_reset();
        load_n = 1'b0; par_d = 4'b1011; tick();
        check_q("R3");
        #5 rst_n = 1'b0;
        exp_q = '0;
        #1 check_q("R1");
        par_d = 4'b1111; load_n = 1'b0;
        tick();
        check_q("R2");
        #3 rst_n = 1'b1;
        #4 check_q("R2");
        tick();
        check_q("R2");
    endtask

    task automatic t_between_edges();
        load_n = 1'b0; par_d = 4'b0011; tick();
        par_d = 4'b1100; #3;
        load_n = 1'b1; ser_j = 1'b1; ser_kb = 1'b1; #3;
        check_q("R10");
        load_n = 1'b0; par_d = 4'b1001;
        tick();
        check_q("R10");
    endtask

    initial begin
        t_reset();
        t_load();
        t_shift();
        t_entry();
        t_mid_reset();
        t_between_edges();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule